// File: doc/BRIEF.md
# Interrupt and Subroutine Stack Sequencer

This block is the control sequencer that an 8-bit processor with a 16-bit address space uses to save and restore its program counter and flags. It carries out the stack traffic for the software trap (BRK), the subroutine call (JSR), the subroutine return (RTS) and the interrupt return (RTI). It also services maskable (IRQ) and non-maskable (NMI) interrupt requests. The surrounding core supplies the current program counter, flags, stack pointer and call target. It then raises either a start strobe with the opcode or one of the request lines.

The sequencer drives a byte-wide memory port that carries one access per cycle. All three traps (BRK, IRQ and NMI) push three bytes and then read a two-byte vector in little-endian order. The call pushes two bytes. The returns pull two or three bytes. At the end of every sequence the block presents the new program counter, flags and stack pointer, and pulses a done strobe for one cycle. Those outputs hold until the next sequence completes. Requests are only looked at while no sequence is running. The core is expected to drop a request once it has been taken.

Top module: `stack_seq`

## Requirements
- R1: With start high while idle, the opcode selects the sequence. 0x00 is the trap (BRK), 0x20 the call (JSR), 0x40 the interrupt return (RTI) and 0x60 the subroutine return (RTS). Any other opcode is ignored: it causes no memory access and no done pulse.
- R2: A trap writes three bytes: the PC high byte at 0x0100+SP, the PC low byte at 0x0100+SP-1 and the status byte at 0x0100+SP-2. The final stack pointer is SP-3.
- R3: In the pushed status byte, bit 5 is 1 and bit 4 (break) is 1 for BRK and 0 for IRQ or NMI. All other bits equal status_in.
- R4: BRK and IRQ read 0xFFFE and then 0xFFFF. NMI reads 0xFFFA and then 0xFFFB. The new PC takes its high byte from the higher address and its low byte from the lower address. status_out is status_in with bit 2 (interrupt mask) set.
- R5: While idle, the request priority is NMI, then IRQ, then start. IRQ is ignored while status_in bit 2 is 1. NMI is never masked.
- R6: JSR writes (pc_in-1) high byte at 0x0100+SP and low byte at 0x0100+SP-1. pc_out becomes target_in, sp_out becomes SP-2 and status_out equals status_in.
- R7: RTS reads the low byte at 0x0100+SP+1 and the high byte at 0x0100+SP+2. pc_out is that value plus one, modulo 2^16. sp_out is SP+2 and status_out equals status_in.
- R8: RTI reads the status at 0x0100+SP+1, the PC low byte at SP+2 and the PC high byte at SP+3. status_out is the pulled byte unchanged, pc_out is {high,low} and sp_out is SP+3.
- R9: The stack pointer wraps modulo 256 and every stack access stays in page 0x01.
- R10: There is one memory access per cycle, never a read and a write together, starting the cycle after acceptance. A trap takes 5 accesses, JSR 2, RTS 2 and RTI 3. done is a single-cycle pulse in the cycle after the last access. pc_out, status_out and sp_out hold between done pulses.
- R11: start, irq_req and nmi_req are ignored while a sequence is running.
- R12: While rst_n is low at a clock edge, done, mem_wr and mem_rd go low, and pc_out, status_out and sp_out go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to run the sequence selected by opcode |
| opcode | input | 8 | Opcode of the instruction to sequence |
| irq_req | input | 1 | Maskable interrupt request (level) |
| nmi_req | input | 1 | Non-maskable interrupt request (level) |
| pc_in | input | 16 | Current program counter (address of the next instruction) |
| status_in | input | 8 | Current status register |
| sp_in | input | 8 | Current stack pointer |
| target_in | input | 16 | Subroutine target address for JSR |
| mem_addr | output | 16 | Memory address of the current access |
| mem_wr | output | 1 | Write strobe for this cycle |
| mem_rd | output | 1 | Read strobe for this cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| pc_out | output | 16 | Program counter produced by the last sequence |
| status_out | output | 8 | Status register produced by the last sequence |
| sp_out | output | 8 | Stack pointer produced by the last sequence |
| done | output | 1 | One-cycle pulse when a sequence has completed |

## Verification
The hardest situations to reach are requests that arrive together or at the wrong moment. The bench drives two requests in the same idle cycle so that the NMI-over-IRQ and IRQ-over-start priorities show up in the chosen vector and in the pushed break bit. It also raises NMI in the first busy cycle of a return, which must leave no trace in the results. The stack wrap is reached by starting a trap with the pointer at 0x01 and a return with it at 0xFF. A scoreboard compares every write address and data byte, in order, against values the driver derives from the requirements.

// File: rtl/ssq_pkg.sv
// Package: shared types for the stack sequencer.
// Holds the sequence kinds, the per-step control word and the flag bit
// positions. Assumes an 8-bit status byte with the usual bit layout.
package ssq_pkg;

    localparam int STEP_W = 3;     // enough for the five-step trap
    localparam int FLAG_MASK = 2;  // interrupt mask bit
    localparam int FLAG_BRK = 4;   // break marker in the pushed copy
    localparam int FLAG_ONE = 5;   // always-one bit in the pushed copy

    typedef enum logic [2:0] {
        K_BRK, K_IRQ, K_NMI, K_JSR, K_RTS, K_RTI
    } kind_e;

    typedef enum logic [1:0] {ACC_NONE, ACC_WR, ACC_RD} acc_e;
    typedef enum logic [1:0] {AD_PUSH, AD_POP, AD_VLO, AD_VHI} adr_e;
    typedef enum logic [1:0] {FL_PCH, FL_PCL, FL_STAT} fld_e;

    typedef struct packed {
        acc_e acc;
        adr_e adr;
        fld_e fld;
        logic last;
    } step_t;

endpackage

// File: rtl/ssq_select.sv
// Module: ssq_select
// Picks the sequence to start from the request lines while the sequencer
// is idle. Priority is NMI, then unmasked IRQ, then a start with a known
// opcode. Purely combinational; the caller only uses it while idle.
module ssq_select
    import ssq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] OPC_BRK = 8'h00,
    parameter logic [DATA_W-1:0] OPC_JSR = 8'h20,
    parameter logic [DATA_W-1:0] OPC_RTI = 8'h40,
    parameter logic [DATA_W-1:0] OPC_RTS = 8'h60
) (
    input  logic              start,
    input  logic [DATA_W-1:0] opcode,
    input  logic              irq_req,
    input  logic              nmi_req,
    input  logic              irq_mask,
    output logic              take,
    output kind_e             kind
);

    // Priority choice between interrupt lines and software requests.
    always_comb begin
        take = 1'b0;
        kind = K_BRK;
        if (nmi_req) begin
            take = 1'b1;
            kind = K_NMI;
        end else if (irq_req && !irq_mask) begin
            take = 1'b1;
            kind = K_IRQ;
        end else if (start) begin
            if (opcode == OPC_BRK) begin
                take = 1'b1;
                kind = K_BRK;
            end else if (opcode == OPC_JSR) begin
                take = 1'b1;
                kind = K_JSR;
            end else if (opcode == OPC_RTI) begin
                take = 1'b1;
                kind = K_RTI;
            end else if (opcode == OPC_RTS) begin
                take = 1'b1;
                kind = K_RTS;
            end
        end
    end

endmodule

// File: rtl/ssq_plan.sv
// Module: ssq_plan
// Step table of the sequencer: for a kind and a step index it gives the
// access type, the address source, the byte field moved and whether the
// step is the last one. Out-of-range steps report "last" so a stray state
// ends the sequence.
module ssq_plan
    import ssq_pkg::*;
(
    input  kind_e             kind,
    input  logic [STEP_W-1:0] step,
    output step_t             ctl
);

    function automatic step_t mk(acc_e a, adr_e d, fld_e f, logic l);
        step_t s;
        s.acc  = a;
        s.adr  = d;
        s.fld  = f;
        s.last = l;
        return s;
    endfunction

    // Decode one step of the selected sequence.
    always_comb begin
        ctl = mk(ACC_NONE, AD_PUSH, FL_PCH, 1'b1);
        unique case (kind)
            K_BRK, K_IRQ, K_NMI: begin
                case (step)
                    3'd0: ctl = mk(ACC_WR, AD_PUSH, FL_PCH, 1'b0);
                    3'd1: ctl = mk(ACC_WR, AD_PUSH, FL_PCL, 1'b0);
                    3'd2: ctl = mk(ACC_WR, AD_PUSH, FL_STAT, 1'b0);
                    3'd3: ctl = mk(ACC_RD, AD_VLO, FL_PCL, 1'b0);
                    3'd4: ctl = mk(ACC_RD, AD_VHI, FL_PCH, 1'b1);
                    default: ;
                endcase
            end
            K_JSR: begin
                case (step)
                    3'd0: ctl = mk(ACC_WR, AD_PUSH, FL_PCH, 1'b0);
                    3'd1: ctl = mk(ACC_WR, AD_PUSH, FL_PCL, 1'b1);
                    default: ;
                endcase
            end
            K_RTS: begin
                case (step)
                    3'd0: ctl = mk(ACC_RD, AD_POP, FL_PCL, 1'b0);
                    3'd1: ctl = mk(ACC_RD, AD_POP, FL_PCH, 1'b1);
                    default: ;
                endcase
            end
            K_RTI: begin
                case (step)
                    3'd0: ctl = mk(ACC_RD, AD_POP, FL_STAT, 1'b0);
                    3'd1: ctl = mk(ACC_RD, AD_POP, FL_PCL, 1'b0);
                    3'd2: ctl = mk(ACC_RD, AD_POP, FL_PCH, 1'b1);
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stack_seq.sv
// Module: stack_seq (top)
// Multi-cycle sequencer for the trap, call, return and interrupt stack
// traffic of an 8-bit core. It latches the core state when a request is
// taken, walks the step table with one memory access per cycle and then
// publishes the new PC, status and stack pointer with a done pulse.
// Assumes mem_rdata is valid in the same cycle as mem_addr and that the
// core drops a request once the sequence has started.
module stack_seq
    import ssq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0]   STACK_PAGE = 8'h01,
    parameter logic [2*DATA_W-1:0] VEC_NMI    = 16'hFFFA,
    parameter logic [2*DATA_W-1:0] VEC_TRAP   = 16'hFFFE,
    parameter logic [DATA_W-1:0]   OPC_BRK    = 8'h00,
    parameter logic [DATA_W-1:0]   OPC_JSR    = 8'h20,
    parameter logic [DATA_W-1:0]   OPC_RTI    = 8'h40,
    parameter logic [DATA_W-1:0]   OPC_RTS    = 8'h60
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DATA_W-1:0]   opcode,
    input  logic                irq_req,
    input  logic                nmi_req,
    input  logic [2*DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0]   status_in,
    input  logic [DATA_W-1:0]   sp_in,
    input  logic [2*DATA_W-1:0] target_in,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic                mem_wr,
    output logic                mem_rd,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [2*DATA_W-1:0] pc_out,
    output logic [DATA_W-1:0]   status_out,
    output logic [DATA_W-1:0]   sp_out,
    output logic                done
);

    localparam int AW = 2 * DATA_W;

    logic              busy_q;
    kind_e             kind_q;
    logic [STEP_W-1:0] step_q;
    logic [DATA_W-1:0] sp_q, st_q, lo_q;
    logic [AW-1:0]     pc_q, tgt_q;

    logic              take;
    kind_e             take_kind;
    step_t             cur;

    logic [DATA_W-1:0] sp_up, sp_dn, sp_nx, push_stat;
    logic [AW-1:0]     vec_base, pc_fin;
    logic [DATA_W-1:0] stat_fin;
    logic              is_trap;

    ssq_select #(
        .DATA_W (DATA_W),
        .OPC_BRK(OPC_BRK),
        .OPC_JSR(OPC_JSR),
        .OPC_RTI(OPC_RTI),
        .OPC_RTS(OPC_RTS)
    ) u_sel (
        .start   (start),
        .opcode  (opcode),
        .irq_req (irq_req),
        .nmi_req (nmi_req),
        .irq_mask(status_in[FLAG_MASK]),
        .take    (take),
        .kind    (take_kind)
    );

    ssq_plan u_plan (
        .kind(kind_q),
        .step(step_q),
        .ctl (cur)
    );

    // Stack pointer neighbours and the pointer after the current step.
    always_comb begin
        sp_up = sp_q + 1'b1;
        sp_dn = sp_q - 1'b1;
        sp_nx = sp_q;
        if (busy_q && cur.acc != ACC_NONE) begin
            if (cur.adr == AD_PUSH) sp_nx = sp_dn;
            if (cur.adr == AD_POP)  sp_nx = sp_up;
        end
    end

    // Memory address from the step's address source.
    always_comb begin
        vec_base = (kind_q == K_NMI) ? VEC_NMI : VEC_TRAP;
        unique case (cur.adr)
            AD_PUSH: mem_addr = {STACK_PAGE, sp_q};
            AD_POP:  mem_addr = {STACK_PAGE, sp_up};
            AD_VLO:  mem_addr = vec_base;
            default: mem_addr = vec_base + 1'b1;
        endcase
    end

    // Strobes and write data for the current step.
    always_comb begin
        mem_wr = busy_q && (cur.acc == ACC_WR);
        mem_rd = busy_q && (cur.acc == ACC_RD);
        push_stat = st_q;
        push_stat[FLAG_ONE] = 1'b1;
        push_stat[FLAG_BRK] = (kind_q == K_BRK);
        unique case (cur.fld)
            FL_PCH:  mem_wdata = pc_q[AW-1:DATA_W];
            FL_PCL:  mem_wdata = pc_q[DATA_W-1:0];
            default: mem_wdata = push_stat;
        endcase
    end

    // Results published when the last step completes.
    always_comb begin
        is_trap = (kind_q == K_BRK) || (kind_q == K_IRQ) || (kind_q == K_NMI);
        if (kind_q == K_JSR)
            pc_fin = tgt_q;
        else
            pc_fin = {mem_rdata, lo_q} + {{(AW-1){1'b0}}, (kind_q == K_RTS)};
        stat_fin = st_q;
        if (is_trap) stat_fin[FLAG_MASK] = 1'b1;
    end

    // Sequencer state: accept when idle, advance one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            kind_q     <= K_BRK;
            step_q     <= '0;
            sp_q       <= '0;
            st_q       <= '0;
            lo_q       <= '0;
            pc_q       <= '0;
            tgt_q      <= '0;
            pc_out     <= '0;
            status_out <= '0;
            sp_out     <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy_q) begin
                if (take) begin
                    busy_q <= 1'b1;
                    kind_q <= take_kind;
                    step_q <= '0;
                    sp_q   <= sp_in;
                    st_q   <= status_in;
                    tgt_q  <= target_in;
                    pc_q   <= (take_kind == K_JSR) ? pc_in - 1'b1 : pc_in;
                end
            end else begin
                sp_q   <= sp_nx;
                step_q <= step_q + 1'b1;
                if (cur.acc == ACC_RD) begin
                    if (cur.fld == FL_STAT) st_q <= mem_rdata;
                    if (cur.fld == FL_PCL)  lo_q <= mem_rdata;
                end
                if (cur.last) begin
                    busy_q     <= 1'b0;
                    done       <= 1'b1;
                    pc_out     <= pc_fin;
                    status_out <= stat_fin;
                    sp_out     <= sp_nx;
                end
            end
        end
    end

    // ---------------- assertions ----------------
    p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_stack_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_addr[AW-1:DATA_W] == STACK_PAGE);

    p_push_descend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |->
            mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) - 1'b1);

    p_pop_ascend_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd) && mem_addr[AW-1:DATA_W] == STACK_PAGE
         && $past(mem_addr[AW-1:DATA_W]) == STACK_PAGE) |->
            mem_addr[DATA_W-1:0] == $past(mem_addr[DATA_W-1:0]) + 1'b1);

    p_nmi_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && nmi_req) |=> (busy_q && kind_q == K_NMI));

    p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && irq_req && status_in[FLAG_MASK] && !nmi_req && !start)
            |=> !busy_q);

    p_hold_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q)) |-> kind_q == $past(kind_q));

endmodule

// File: tb/stack_seq_test.sv
`timescale 1ns/1ps
module stack_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        irq_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  status_in = '0;
    logic [7:0]  sp_in = '0;
    logic [15:0] target_in = '0;
    logic [15:0] mem_addr;
    logic        mem_wr, mem_rd;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] pc_out;
    logic [7:0]  status_out, sp_out;
    logic        done;

    always #2.5 clk = ~clk;

    stack_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .irq_req(irq_req), .nmi_req(nmi_req), .pc_in(pc_in),
        .status_in(status_in), .sp_in(sp_in), .target_in(target_in),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_out(pc_out),
        .status_out(status_out), .sp_out(sp_out), .done(done)
    );

    // memory model: stack page plus fixed vectors
    logic [7:0] stk [0:255];
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0, pre_data = '0;

    function automatic logic [7:0] vec_byte(input logic [2:0] a);
        case (a)
            3'd2: return 8'h34;   // FFFA
            3'd3: return 8'h12;   // FFFB
            3'd6: return 8'hCD;   // FFFE
            3'd7: return 8'hAB;   // FFFF
            default: return 8'h00;
        endcase
    endfunction

    assign mem_rdata = (mem_addr[15:8] == 8'hFF) ? vec_byte(mem_addr[2:0])
                                                 : stk[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_wr) stk[mem_addr[7:0]] <= mem_wdata;
        else if (pre_we) stk[pre_addr] <= pre_data;
    end

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int acc_cnt = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // scoreboard queues
    logic [15:0] wq_addr[$];
    logic [7:0]  wq_data[$];
    string       wq_tag[$];
    logic [15:0] rq_pc[$];
    logic [7:0]  rq_st[$];
    logic [7:0]  rq_sp[$];
    string       rq_tag[$];

    task automatic push_w(input logic [15:0] a, input logic [7:0] d, input string t);
        wq_addr.push_back(a); wq_data.push_back(d); wq_tag.push_back(t);
    endtask

    task automatic push_r(input logic [15:0] p, input logic [7:0] s,
                          input logic [7:0] sp, input string t);
        rq_pc.push_back(p); rq_st.push_back(s); rq_sp.push_back(sp); rq_tag.push_back(t);
    endtask

    // monitor: compare writes and results as they appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_wr || mem_rd) acc_cnt++;
            if (mem_wr) begin
                if (wq_addr.size() == 0) begin
                    chk(1'b0, "R1", "unexpected write addr", {16'h0, mem_addr}, 32'h0);
                end else begin
                    logic [15:0] ea; logic [7:0] ed; string et;
                    ea = wq_addr.pop_front(); ed = wq_data.pop_front(); et = wq_tag.pop_front();
                    chk(mem_addr == ea, et, "write address", {16'h0, mem_addr}, {16'h0, ea});
                    chk(mem_wdata == ed, et, "write data", {24'h0, mem_wdata}, {24'h0, ed});
                end
            end
            if (done) begin
                done_cnt++;
                if (rq_pc.size() == 0) begin
                    chk(1'b0, "R1", "unexpected done", 32'h1, 32'h0);
                end else begin
                    logic [15:0] ep; logic [7:0] es, esp; string et;
                    ep = rq_pc.pop_front(); es = rq_st.pop_front();
                    esp = rq_sp.pop_front(); et = rq_tag.pop_front();
                    chk(pc_out == ep, et, "pc_out", {16'h0, pc_out}, {16'h0, ep});
                    chk(status_out == es, et, "status_out", {24'h0, status_out}, {24'h0, es});
                    chk(sp_out == esp, et, "sp_out", {24'h0, sp_out}, {24'h0, esp});
                end
            end
        end
    end

    task automatic preload(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk); pre_we = 1'b0;
    endtask

    // expected trap traffic (R2, R3, R4)
    task automatic expect_trap(input bit brk, input bit nmi, input logic [15:0] pc,
                               input logic [7:0] st, input logic [7:0] sp, input string t);
        logic [7:0] ps, s1, s2, s3;
        ps = st | 8'h20; ps[4] = brk;
        s1 = sp - 8'd1; s2 = sp - 8'd2; s3 = sp - 8'd3;
        push_w({8'h01, sp}, pc[15:8], t);
        push_w({8'h01, s1}, pc[7:0], t);
        push_w({8'h01, s2}, ps, t);
        push_r(nmi ? 16'h1234 : 16'hABCD, st | 8'h04, s3, t);
    endtask

    // driver: apply one request and measure the latency to done
    task automatic issue(input bit s, input logic [7:0] opc, input bit irq, input bit nmi,
                         input bit late_nmi, input logic [15:0] pc, input logic [7:0] st,
                         input logic [7:0] sp, input logic [15:0] tgt,
                         input int exp_lat, input string t);
        int lat;
        lat = 0;
        @(negedge clk);
        start = s; opcode = opc; irq_req = irq; nmi_req = nmi;
        pc_in = pc; status_in = st; sp_in = sp; target_in = tgt;
        for (int i = 1; i <= 20 && lat == 0; i++) begin
            @(negedge clk);
            if (i == 1) begin
                start = 1'b0; irq_req = 1'b0; nmi_req = late_nmi;
            end else begin
                nmi_req = 1'b0;
            end
            if (done) lat = i;
        end
        chk(lat == exp_lat, t, "latency to done (R10)", lat, exp_lat);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done pulse width", {31'h0, done}, 32'h0);
    endtask

    // a request that must be ignored: no access, no done, outputs held
    task automatic poke(input bit s, input logic [7:0] opc, input bit irq,
                        input logic [7:0] st, input string t);
        int d0, a0;
        logic [15:0] p0;
        d0 = done_cnt; a0 = acc_cnt; p0 = pc_out;
        @(negedge clk);
        start = s; opcode = opc; irq_req = irq; status_in = st;
        @(negedge clk);
        start = 1'b0; irq_req = 1'b0;
        repeat (8) @(negedge clk);
        chk(done_cnt == d0, t, "ignored request gave done", done_cnt, d0);
        chk(acc_cnt == a0, t, "ignored request gave access", acc_cnt, a0);
        chk(pc_out == p0, t, "pc_out held (R10)", {16'h0, pc_out}, {16'h0, p0});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(done == 1'b0, "R12", "done in reset", {31'h0, done}, 32'h0);
        chk(mem_wr == 1'b0 && mem_rd == 1'b0, "R12", "strobes in reset",
            {30'h0, mem_wr, mem_rd}, 32'h0);
        chk(pc_out == 16'h0 && status_out == 8'h0 && sp_out == 8'h0, "R12",
            "outputs in reset", {pc_out, sp_out, status_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4: software trap
        expect_trap(1'b1, 1'b0, 16'h0302, 8'h81, 8'hFD, "R3_brk");
        issue(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0302, 8'h81, 8'hFD, 16'h0, 6, "R2_brk");

        // R4: maskable interrupt, pushed break bit cleared
        expect_trap(1'b0, 1'b0, 16'h4000, 8'hD3, 8'h80, "R4_irq");
        issue(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h4000, 8'hD3, 8'h80, 16'h0, 6, "R4_irq");

        // R4 R5: NMI while mask set uses its own vector
        expect_trap(1'b0, 1'b1, 16'h1111, 8'h07, 8'h40, "R4_nmi");
        issue(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'h1111, 8'h07, 8'h40, 16'h0, 6, "R4_nmi");

        // R5: masked IRQ ignored
        poke(1'b0, 8'h00, 1'b1, 8'h04, "R5_masked");

        // R5: NMI beats IRQ
        expect_trap(1'b0, 1'b1, 16'h2222, 8'h00, 8'h30, "R5_nmi_irq");
        issue(1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 16'h2222, 8'h00, 8'h30, 16'h0, 6, "R5_nmi_irq");

        // R5: IRQ beats a BRK start (break bit stays clear)
        expect_trap(1'b0, 1'b0, 16'h3333, 8'h00, 8'h20, "R5_irq_start");
        issue(1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 16'h3333, 8'h00, 8'h20, 16'h0, 6, "R5_irq_start");

        // R5: NMI beats a BRK start
        expect_trap(1'b0, 1'b1, 16'h4444, 8'h00, 8'h60, "R5_nmi_start");
        issue(1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 16'h4444, 8'h00, 8'h60, 16'h0, 6, "R5_nmi_start");

        // R6: subroutine call
        push_w(16'h01F0, 8'h20, "R6_jsr");
        push_w(16'h01EF, 8'h02, "R6_jsr");
        push_r(16'h5678, 8'h55, 8'hEE, "R6_jsr");
        issue(1'b1, 8'h20, 1'b0, 1'b0, 1'b0, 16'h2003, 8'h55, 8'hF0, 16'h5678, 3, "R6_jsr");

        // R7: subroutine return, uses bytes written by the call
        push_r(16'h2003, 8'h3C, 8'hF0, "R7_rts");
        issue(1'b1, 8'h60, 1'b0, 1'b0, 1'b0, 16'h0, 8'h3C, 8'hEE, 16'h0, 3, "R7_rts");

        // R8: interrupt return
        preload(8'h11, 8'hA5);
        preload(8'h12, 8'h78);
        preload(8'h13, 8'h56);
        push_r(16'h5678, 8'hA5, 8'h13, "R8_rti");
        issue(1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 16'h0, 8'h00, 8'h10, 16'h0, 4, "R8_rti");

        // R1: unknown opcodes ignored
        poke(1'b1, 8'h08, 1'b0, 8'h00, "R1_unknown");
        poke(1'b1, 8'hEA, 1'b0, 8'h00, "R1_unknown");

        // R9: pointer wraps through zero on push
        expect_trap(1'b1, 1'b0, 16'h9ABC, 8'h00, 8'h01, "R9_push_wrap");
        issue(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 16'h9ABC, 8'h00, 8'h01, 16'h0, 6, "R9_push_wrap");

        // R9 R7: pop wraps, PC increment wraps
        preload(8'h00, 8'hFF);
        preload(8'h01, 8'hFF);
        push_r(16'h0000, 8'h00, 8'h01, "R9_pop_wrap");
        issue(1'b1, 8'h60, 1'b0, 1'b0, 1'b0, 16'h0, 8'h00, 8'hFF, 16'h0, 3, "R9_pop_wrap");

        // R11: NMI during a running return is ignored
        preload(8'h51, 8'h10);
        preload(8'h52, 8'h80);
        push_r(16'h8011, 8'h00, 8'h52, "R11_busy");
        issue(1'b1, 8'h60, 1'b0, 1'b0, 1'b1, 16'h0, 8'h00, 8'h50, 16'h0, 3, "R11_busy");
        poke(1'b0, 8'h00, 1'b0, 8'h00, "R11_after");

        chk(wq_addr.size() == 0 && rq_pc.size() == 0, "R10", "scoreboard drained",
            wq_addr.size() + rq_pc.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule